// File: doc/BRIEF.md
# Hypervisor interrupt routing controller

This block holds a 64-bit hypervisor configuration word and turns it into routing decisions for the three asynchronous interrupt classes: IRQ, FIQ and SError. Software writes the word through a write strobe with write data, and reads it back on a read-data bus that is always valid. From the stored word and a few live inputs (current exception level, whether the hypervisor level is enabled in the current security state, a per-class "claimed by the monitor level" flag and a strap saying whether the host virtualization extension exists), the block drives, for each class, whether the physical interrupt is taken to the hypervisor level and whether the virtual interrupt is enabled. It also flags an exception return to the kernel level as illegal.

The key subtlety is the split between the stored and the effective routing bits. A read always returns what was written. Routing, however, uses effective values: when the hypervisor level is enabled and the general-trap bit is set, the three routing bits are overridden to 1, or to 0 when host mode is set and the host extension is present. The effective bits are also brought out on a port so the override can be observed directly.

Per-class vectors use bit 0 for IRQ, bit 1 for FIQ and bit 2 for SError.

Top module: `hyp_irq_router`

## Requirements
- R1: After reset the stored word is all zeros, `cfg_rdata` reads 0 and `eret_el1_illegal`, `phys_to_el2`, `virt_enable` and `eff_route` are all 0.
- R2: A write with `cfg_we`=1 updates the stored word at the next rising clock edge. Right after that edge, `cfg_rdata` and every derived output reflect the new value. Implemented bit positions are: pointer-auth instruction control 41, pointer-auth key access control 40, synchronous abort routing 37, host mode 34, general trap 27, SError routing 5, IRQ routing 4, FIQ routing 3.
- R3: Bit positions not listed in R2 read as 0 whatever is written.
- R4: `cfg_rdata` returns the stored routing bits 5, 4 and 3, never their effective values.
- R5: `eff_route[i]` is 1 when `el2_enable`=1 and general trap=1, unless host mode=1 and `host_ext_present`=1, in which case it is 0. In every other case `eff_route[i]` equals the stored routing bit. This means general trap has no effect when `el2_enable`=0.
- R6: `phys_to_el2[i]` is 1 when `el2_enable`=1, `eff_route[i]`=1, `el3_claim[i]`=0 and `cur_el`≠3.
- R7: With `el2_enable`=1 and general trap=1, IRQ and FIQ (bits 0 and 1) are taken to the hypervisor level whatever their routing bits or the host mode hold, unless claimed by the monitor level or `cur_el`=3. SError follows `eff_route[2]` only.
- R8: `el3_claim[i]`=1 forces `phys_to_el2[i]` to 0.
- R9: With `el2_enable`=0, all `phys_to_el2` bits are 0. With the effective routing bit 0 and general trap 0, the class is not taken to the hypervisor level.
- R10: `virt_enable[i]` is 1 only when `el2_enable`=1, general trap=0 and the stored routing bit i is 1. It is 0 whenever general trap is 1.
- R11: `eret_el1_illegal` is 1 exactly when `el2_enable`=1 and general trap=1.
- R12: When `cur_el`=3, no `phys_to_el2` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Stored configuration word (unimplemented bits 0) |
| cur_el | input | 2 | Current exception level 0..3 |
| el2_enable | input | 1 | Hypervisor level enabled in current security state |
| el3_claim | input | 3 | Per class: interrupt routed to the monitor level |
| host_ext_present | input | 1 | Strap: host virtualization extension implemented |
| phys_to_el2 | output | 3 | Per class: physical interrupt taken to hypervisor level |
| virt_enable | output | 3 | Per class: virtual interrupt enabled |
| eff_route | output | 3 | Per class: effective routing bit |
| eret_el1_illegal | output | 1 | Exception return to kernel level is illegal |

## Verification
The hardest case to reach is the one where the effective routing bits differ from the stored ones. It needs general trap and host mode set together with the strap, while the stored routing bits are held at the opposite value. The stimulus writes words with the routing bits cleared and general trap set, then flips the host mode bit and the strap. This exposes the 1 and the 0 overrides on `eff_route` and on SError routing, while a readback of the same word shows the untouched stored bits. The same word is then replayed with `el2_enable` low to show the override disappears.

// File: rtl/hyp_irq_pkg.sv
package hyp_irq_pkg;

    localparam int unsigned CFG_W      = 64;
    localparam int unsigned N_CLASS    = 3;
    localparam int unsigned EL_W       = 2;

    // Bit positions software decodes
    localparam int unsigned POS_AUTH_INSTR = 41;
    localparam int unsigned POS_AUTH_KEY   = 40;
    localparam int unsigned POS_SYNC_ABT   = 37;
    localparam int unsigned POS_HOST_MODE  = 34;
    localparam int unsigned POS_GEN_TRAP   = 27;
    localparam int unsigned POS_RT_SERR    = 5;
    localparam int unsigned POS_RT_IRQ     = 4;
    localparam int unsigned POS_RT_FIQ     = 3;

    typedef enum int unsigned {
        CLS_IRQ  = 0,
        CLS_FIQ  = 1,
        CLS_SERR = 2
    } irq_class_e;

    localparam logic [EL_W-1:0] EL_MONITOR = 2'd3;

    typedef struct packed {
        logic               auth_instr;
        logic               auth_key;
        logic               sync_abt;
        logic               host_mode;
        logic               gen_trap;
        logic [N_CLASS-1:0] route;   // [0]=IRQ [1]=FIQ [2]=SError
    } cfg_t;

    localparam cfg_t CFG_RESET = '0;

    function automatic logic [CFG_W-1:0] impl_mask();
        logic [CFG_W-1:0] m;
        m = '0;
        m[POS_AUTH_INSTR] = 1'b1;
        m[POS_AUTH_KEY]   = 1'b1;
        m[POS_SYNC_ABT]   = 1'b1;
        m[POS_HOST_MODE]  = 1'b1;
        m[POS_GEN_TRAP]   = 1'b1;
        m[POS_RT_SERR]    = 1'b1;
        m[POS_RT_IRQ]     = 1'b1;
        m[POS_RT_FIQ]     = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/hyp_cfg_store.sv
module hyp_cfg_store
    import hyp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output cfg_t             cfg
);

    localparam logic [CFG_W-1:0] MASK = impl_mask();

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.auth_instr          = wdata[POS_AUTH_INSTR];
            cfg_d.auth_key            = wdata[POS_AUTH_KEY];
            cfg_d.sync_abt            = wdata[POS_SYNC_ABT];
            cfg_d.host_mode           = wdata[POS_HOST_MODE];
            cfg_d.gen_trap            = wdata[POS_GEN_TRAP];
            cfg_d.route[CLS_IRQ]      = wdata[POS_RT_IRQ];
            cfg_d.route[CLS_FIQ]      = wdata[POS_RT_FIQ];
            cfg_d.route[CLS_SERR]     = wdata[POS_RT_SERR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                 = '0;
        rdata[POS_AUTH_INSTR] = cfg_q.auth_instr;
        rdata[POS_AUTH_KEY]   = cfg_q.auth_key;
        rdata[POS_SYNC_ABT]   = cfg_q.sync_abt;
        rdata[POS_HOST_MODE]  = cfg_q.host_mode;
        rdata[POS_GEN_TRAP]   = cfg_q.gen_trap;
        rdata[POS_RT_IRQ]     = cfg_q.route[CLS_IRQ];
        rdata[POS_RT_FIQ]     = cfg_q.route[CLS_FIQ];
        rdata[POS_RT_SERR]    = cfg_q.route[CLS_SERR];
    end

    assign cfg = cfg_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & MASK)));                  // R2
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~MASK) == '0);                                    // R3
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));                                   // R2

endmodule

// File: rtl/hyp_eff_eval.sv
module hyp_eff_eval
    import hyp_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg,
    input  logic               el2_enable,
    input  logic               host_ext_present,
    output logic [N_CLASS-1:0] eff_route,
    output logic               trap_active,
    output logic               eret_illegal
);

    logic host_override;

    always_comb begin
        trap_active   = el2_enable & cfg.gen_trap;
        host_override = cfg.host_mode & host_ext_present;
        if (trap_active) eff_route = host_override ? '0 : '1;
        else             eff_route = cfg.route;
        eret_illegal  = trap_active;
    end

    AST_NO_TRAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !el2_enable |-> (eff_route == cfg.route));                 // R5
    AST_HOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (el2_enable && cfg.gen_trap && cfg.host_mode && host_ext_present)
        |-> (eff_route == '0));                                    // R5

endmodule

// File: rtl/hyp_class_route.sv
module hyp_class_route
    import hyp_irq_pkg::*;
#(
    parameter bit TRAP_FORCES = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EL_W-1:0] cur_el,
    input  logic            el2_enable,
    input  logic            trap_active,
    input  logic            stored_route,
    input  logic            eff_route,
    input  logic            el3_claim,
    output logic            phys_to_el2,
    output logic            virt_enable
);

    logic want;

    always_comb begin
        want        = eff_route | (TRAP_FORCES & trap_active);
        phys_to_el2 = el2_enable & want & ~el3_claim & (cur_el != EL_MONITOR);
        virt_enable = el2_enable & ~trap_active & stored_route;
    end

    AST_CLAIM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        el3_claim |-> !phys_to_el2);                               // R8
    AST_VIRT_OFF_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_active |-> !virt_enable);                             // R10
    AST_MONITOR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == EL_MONITOR) |-> !phys_to_el2);                  // R12

endmodule

// File: rtl/hyp_irq_router.sv
module hyp_irq_router
    import hyp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [63:0]      cfg_wdata,
    output logic [63:0]      cfg_rdata,
    input  logic [1:0]       cur_el,
    input  logic             el2_enable,
    input  logic [2:0]       el3_claim,
    input  logic             host_ext_present,
    output logic [2:0]       phys_to_el2,
    output logic [2:0]       virt_enable,
    output logic [2:0]       eff_route,
    output logic             eret_el1_illegal
);

    cfg_t cfg;
    logic trap_active;

    hyp_cfg_store i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    hyp_eff_eval i_eval (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg              (cfg),
        .el2_enable       (el2_enable),
        .host_ext_present (host_ext_present),
        .eff_route        (eff_route),
        .trap_active      (trap_active),
        .eret_illegal     (eret_el1_illegal)
    );

    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
        hyp_class_route #(
            .TRAP_FORCES (c != CLS_SERR)
        ) i_route (
            .clk          (clk),
            .rst_n        (rst_n),
            .cur_el       (cur_el),
            .el2_enable   (el2_enable),
            .trap_active  (trap_active),
            .stored_route (cfg.route[c]),
            .eff_route    (eff_route[c]),
            .el3_claim    (el3_claim[c]),
            .phys_to_el2  (phys_to_el2[c]),
            .virt_enable  (virt_enable[c])
        );
    end

    AST_ERET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eret_el1_illegal == (el2_enable && cfg_rdata[POS_GEN_TRAP])); // R11
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !el2_enable |-> (phys_to_el2 == '0 && virt_enable == '0));    // R9
    AST_TRAP_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (el2_enable && cfg_rdata[POS_GEN_TRAP] && cur_el != 2'd3)
        |-> (phys_to_el2[1:0] == ~el3_claim[1:0]));                   // R7

endmodule

// File: tb/test_hyp_irq_router.sv
`timescale 1ns/1ps
module test_hyp_irq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic [1:0]  cur_el = 2'd0;
    logic        el2_enable = 1'b0;
    logic [2:0]  el3_claim = '0;
    logic        host_ext_present = 1'b0;
    logic [2:0]  phys_to_el2, virt_enable, eff_route;
    logic        eret_el1_illegal;

    always #10 clk = ~clk;   // 50 MHz

    hyp_irq_router i_hyp_irq_router (.*);

    typedef struct {
        string       req;
        logic [2:0]  phys, virt, eff;
        logic        eret;
        logic [63:0] rd;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          failures = 0;
    logic [63:0] model_word = '0;
    bit          done = 1'b0;

    localparam logic [63:0] MASK = (64'd1 << 41) | (64'd1 << 40) | (64'd1 << 37) |
                                   (64'd1 << 34) | (64'd1 << 27) | (64'd1 << 5) |
                                   (64'd1 << 4)  | (64'd1 << 3);
    localparam int B_HOST = 34, B_TRAP = 27;

    function automatic item_t predict(string req);
        item_t it;
        logic [2:0] stored;
        logic trap;
        stored  = {model_word[5], model_word[3], model_word[4]};
        trap    = el2_enable && model_word[B_TRAP];
        it.req  = req;
        it.eff  = trap ? ((model_word[B_HOST] && host_ext_present) ? 3'b000 : 3'b111) : stored;
        for (int c = 0; c < 3; c++) begin
            it.phys[c] = el2_enable && !el3_claim[c] && cur_el != 2'd3 &&
                         (it.eff[c] || (trap && c != 2));
            it.virt[c] = el2_enable && !trap && stored[c];
        end
        it.eret = trap;
        it.rd   = model_word;
        return it;
    endfunction

    task automatic wr(input logic [63:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_wdata = ~d;
        model_word = d & MASK;
    endtask

    task automatic chk(input string req, input logic [1:0] el, input logic en,
                       input logic [2:0] cl, input logic strap);
        @(posedge clk); #1;
        cur_el = el; el2_enable = en; el3_claim = cl; host_ext_present = strap;
        sb.push_back(predict(req));
        @(posedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t e;
                e = sb.pop_front();
                checks++;
                if (phys_to_el2 !== e.phys || virt_enable !== e.virt || eff_route !== e.eff ||
                    eret_el1_illegal !== e.eret || cfg_rdata !== e.rd) begin
                    failures++;
                    $display("FAIL %s: phys=%b virt=%b eff=%b eret=%b rd=%h exp phys=%b virt=%b eff=%b eret=%b rd=%h",
                             e.req, phys_to_el2, virt_enable, eff_route, eret_el1_illegal, cfg_rdata,
                             e.phys, e.virt, e.eff, e.eret, e.rd);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1", 2'd0, 1'b1, 3'b000, 1'b0);
        // R2 R3 all ones readback
        wr('1);
        chk("R2_R3", 2'd1, 1'b0, 3'b000, 1'b0);
        // R3 unimplemented-only write reads zero
        wr(~MASK);
        chk("R3", 2'd1, 1'b1, 3'b000, 1'b0);
        // R6 R10 routing bits set, no trap
        wr((64'd1 << 5) | (64'd1 << 4) | (64'd1 << 3));
        chk("R6_R10", 2'd0, 1'b1, 3'b000, 1'b0);
        chk("R6", 2'd2, 1'b1, 3'b000, 1'b1);
        // R8 monitor claims
        chk("R8", 2'd1, 1'b1, 3'b101, 1'b0);
        chk("R8", 2'd0, 1'b1, 3'b010, 1'b0);
        // R12 at monitor level
        chk("R12", 2'd3, 1'b1, 3'b000, 1'b0);
        // R9 disabled
        chk("R9", 2'd0, 1'b0, 3'b000, 1'b0);
        // R9 only IRQ routed, no trap
        wr(64'd1 << 4);
        chk("R9_R6", 2'd0, 1'b1, 3'b000, 1'b0);
        // R7 R5 R4 R11 trap, routing bits clear, host mode clear
        wr(64'd1 << B_TRAP);
        chk("R7_R5_R4_R11", 2'd0, 1'b1, 3'b000, 1'b0);
        chk("R7_R8", 2'd1, 1'b1, 3'b011, 1'b0);
        // R5 trap + host mode + strap: override to 0, serr not taken, irq/fiq still forced
        wr((64'd1 << B_TRAP) | (64'd1 << B_HOST) | (64'd1 << 5));
        chk("R5_R7_R4", 2'd0, 1'b1, 3'b000, 1'b1);
        // R5 host mode without strap: override to 1
        chk("R5", 2'd0, 1'b1, 3'b000, 1'b0);
        // R5 R9 trap without el2 enabled: no effect
        chk("R5_R9_R11", 2'd1, 1'b0, 3'b000, 1'b1);
        // R10 trap off again, virt only for stored bits
        wr((64'd1 << 3) | (64'd1 << B_HOST));
        chk("R10", 2'd0, 1'b1, 3'b000, 1'b1);
        // R2 write then hold
        wr(64'd0);
        chk("R2", 2'd0, 1'b1, 3'b000, 1'b0);
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule